// File: doc/BRIEF.md
# Dual-Convention Byte Stack Engine

This block keeps a 16-bit stack pointer and carries out 8-bit and 16-bit push and pop requests over a byte-wide synchronous memory port. A single mode input picks the stacking convention. In next-free mode the pointer addresses the first unused byte below the stack. In last-used mode it addresses the byte pushed most recently. Both modes move the pointer by the same amount. They differ only in the address where the first byte is placed, and in whether that address is taken before or after the pointer moves. A 16-bit value is always laid out with its high byte at the lower address.

A client raises `op_valid` while `op_ready` is high. The request carries the direction, the width and the write data. The engine then issues one memory byte per cycle, lower address first. The memory answers one cycle after each access. When the last answer comes back, the engine pulses `op_done` and presents any pop data. If the memory flags an error on any byte, the engine pulses `op_fault` with that byte's address, skips any remaining byte, keeps the pointer unchanged and goes back to idle. A direct load port overwrites the pointer while the engine is idle.

The sequencer has four states. `ST_IDLE` waits for a request. `ST_FIRST` issues the lower-address byte. `ST_SECOND` checks the first answer and issues the upper byte (16-bit only). `ST_CHECK` checks the last answer and commits. The transitions are: accept (`ST_IDLE` to `ST_FIRST`), narrow (`ST_FIRST` to `ST_CHECK`), wide (`ST_FIRST` to `ST_SECOND`), continue (`ST_SECOND` to `ST_CHECK`), early abort (`ST_SECOND` to `ST_IDLE` on error) and retire (`ST_CHECK` to `ST_IDLE`, whether or not there is an error).

Top module: `stk_engine`

## Requirements
- R1: After reset, `sp_out` is 0x0000, `op_ready` is 1, and `mem_en`, `op_done` and `op_fault` are 0.
- R2: In next-free mode (`mode_last_used`=0), an 8-bit push (`op_pop`=0, `op_wide`=0) writes `op_wdata[7:0]` at SP, and SP becomes SP-1.
- R3: In next-free mode, a 16-bit push writes `op_wdata[15:8]` at SP-1 and `op_wdata[7:0]` at SP, and SP becomes SP-2.
- R4: In next-free mode, a pop reads from SP+1 (a 16-bit pop takes its high byte from SP+1 and its low byte from SP+2), and SP grows by the width in bytes.
- R5: In last-used mode (`mode_last_used`=1), a push first lowers SP by the width in bytes and then writes at the new SP, with the high byte at the lower address for 16-bit values.
- R6: In last-used mode, a pop reads starting at SP (high byte at SP for 16-bit values), and SP then grows by the width in bytes.
- R7: A request is accepted on a clock edge where `op_valid` and `op_ready` are both 1. `op_done` is high for one cycle, 2 cycles after acceptance for an 8-bit request and 3 cycles after for a 16-bit request. The lower-address byte is accessed first, and `op_ready` is 0 until the engine is back in idle.
- R8: If `mem_err` is high in the cycle after a byte access, `op_fault` pulses with `fault_addr` equal to that byte's address. No `op_done` is given, the second byte of a 16-bit request is not accessed after a first-byte error, SP is unchanged, and the engine returns to idle.
- R9: `sp_load` in idle sets SP to `sp_load_val` on the next edge and holds `op_ready` at 0 in that cycle. `sp_load` while a request is in progress has no effect.
- R10: Pop data appears on `op_rdata` in the `op_done` cycle. For an 8-bit pop it is zero-extended into bits [7:0].
- R11: All pointer and address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_last_used | input | 1 | 0: pointer at first free byte; 1: pointer at last pushed byte |
| op_valid | input | 1 | Request present |
| op_ready | output | 1 | Engine can accept a request this cycle |
| op_pop | input | 1 | 1: pop, 0: push |
| op_wide | input | 1 | 1: 16-bit value, 0: 8-bit value |
| op_wdata | input | 16 | Push value (8-bit pushes use bits [7:0]) |
| op_done | output | 1 | One-cycle completion pulse |
| op_rdata | output | 16 | Pop result, valid with op_done |
| op_fault | output | 1 | One-cycle memory fault pulse |
| fault_addr | output | 16 | Address of the faulting byte, valid with op_fault |
| sp_load | input | 1 | Direct pointer load request |
| sp_load_val | input | 16 | Value for the direct load |
| sp_out | output | 16 | Current stack pointer |
| mem_en | output | 1 | Byte access strobe |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte written |
| mem_rdata | input | 8 | Read byte, one cycle after the access |
| mem_err | input | 1 | Error for the access of the previous cycle |

## Verification
The bench sweeps both conventions, both widths and both directions across pointer values that straddle the 16-bit wrap. It predicts every byte address and every new pointer value arithmetically.

- A mix-up of the two offset rules would read or write one byte away from the expected location, which the pre-filled address-unique memory exposes at once.
- A swapped byte order would show as reversed halves in memory or in `op_rdata`.
- Errors are injected on the first and on the last byte. A design that committed the pointer, kept going after an early error or reported the wrong byte address would leave a changed `sp_out`, an extra access or a mismatched `fault_addr`.
- A pointer load issued mid-request must leave no trace, and an idle load must win over a waiting request.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_CHECK  = 2'd3
    } stk_state_e;

    typedef enum logic {
        CONV_NEXT_FREE = 1'b0,
        CONV_LAST_USED = 1'b1
    } stk_conv_e;

endpackage

// File: rtl/stk_addr_calc.sv
// Derives the first-byte address and the post-operation pointer for a request.
module stk_addr_calc
    import stk_pkg::*;
#(
    parameter int SP_W = 16
) (
    input  logic [SP_W-1:0] sp_i,
    input  stk_conv_e       conv_i,
    input  logic            pop_i,
    input  logic            wide_i,
    output logic [SP_W-1:0] base_o,
    output logic [SP_W-1:0] sp_after_o
);
    localparam logic [SP_W-1:0] ONE = SP_W'(1);
    localparam logic [SP_W-1:0] TWO = SP_W'(2);

    logic [SP_W-1:0] size;

    always_comb begin
        size       = wide_i ? TWO : ONE;
        sp_after_o = pop_i ? (sp_i + size) : (sp_i - size);
        if (pop_i) begin
            base_o = (conv_i == CONV_LAST_USED) ? sp_i : (sp_i + ONE);
        end else begin
            base_o = (conv_i == CONV_LAST_USED) ? (sp_i - size) : (sp_i - size + ONE);
        end
    end
endmodule

// File: rtl/stk_sp_reg.sv
// Stack pointer register: commits from the sequencer or direct loads.
module stk_sp_reg #(
    parameter int              SP_W     = 16,
    parameter logic [SP_W-1:0] SP_RESET = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit_i,
    input  logic [SP_W-1:0] commit_val_i,
    input  logic            load_i,
    input  logic [SP_W-1:0] load_val_i,
    output logic [SP_W-1:0] sp_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_o <= SP_RESET;
        end else if (commit_i) begin
            sp_o <= commit_val_i;
        end else if (load_i) begin
            sp_o <= load_val_i;
        end
    end

    // R9: a load only comes while idle, so it never meets a commit
    p_no_load_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_i && load_i));
endmodule

// File: rtl/stk_fsm.sv
// Request sequencer: byte issue, response checking, commit and abort.
module stk_fsm
    import stk_pkg::*;
#(
    parameter int SP_W   = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_pop_i,
    input  logic              req_wide_i,
    input  logic [2*BYTE_W-1:0] req_wdata_i,
    input  logic              load_pending_i,
    input  logic [SP_W-1:0]   base_i,
    input  logic [SP_W-1:0]   sp_after_i,
    output logic              req_ready_o,
    output logic              busy_o,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [SP_W-1:0]   mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    input  logic              mem_err_i,
    output logic              done_o,
    output logic [2*BYTE_W-1:0] rdata_o,
    output logic              fault_o,
    output logic [SP_W-1:0]   fault_addr_o,
    output logic              commit_o,
    output logic [SP_W-1:0]   commit_val_o
);
    localparam int          DBL_W = 2 * BYTE_W;
    localparam logic [SP_W-1:0] ONE = SP_W'(1);

    stk_state_e        state_q, state_d;
    logic              pop_q, wide_q;
    logic [DBL_W-1:0]  wdata_q;
    logic [SP_W-1:0]   base_q, sp_next_q;
    logic [BYTE_W-1:0] hi_q;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && req_valid_i && !load_pending_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_FIRST;
            ST_FIRST:  state_d = wide_q ? ST_SECOND : ST_CHECK;
            ST_SECOND: state_d = mem_err_i ? ST_IDLE : ST_CHECK;
            ST_CHECK:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // request context and first-byte capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_q     <= 1'b0;
            wide_q    <= 1'b0;
            wdata_q   <= '0;
            base_q    <= '0;
            sp_next_q <= '0;
            hi_q      <= '0;
        end else begin
            if (accept) begin
                pop_q     <= req_pop_i;
                wide_q    <= req_wide_i;
                wdata_q   <= req_wdata_i;
                base_q    <= base_i;
                sp_next_q <= sp_after_i;
            end
            if (state_q == ST_SECOND) hi_q <= mem_rdata_i;
        end
    end

    // outputs
    always_comb begin
        req_ready_o  = 1'b0;
        busy_o       = 1'b1;
        mem_en_o     = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = base_q;
        mem_wdata_o  = '0;
        done_o       = 1'b0;
        rdata_o      = '0;
        fault_o      = 1'b0;
        fault_addr_o = '0;
        commit_o     = 1'b0;
        commit_val_o = sp_next_q;
        unique case (state_q)
            ST_IDLE: begin
                busy_o      = 1'b0;
                req_ready_o = !load_pending_i;
            end
            ST_FIRST: begin
                mem_en_o    = 1'b1;
                mem_we_o    = !pop_q;
                mem_addr_o  = base_q;
                mem_wdata_o = wide_q ? wdata_q[DBL_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
            end
            ST_SECOND: begin
                fault_o      = mem_err_i;
                fault_addr_o = base_q;
                mem_en_o     = !mem_err_i;
                mem_we_o     = !pop_q && !mem_err_i;
                mem_addr_o   = base_q + ONE;
                mem_wdata_o  = wdata_q[BYTE_W-1:0];
            end
            ST_CHECK: begin
                fault_o      = mem_err_i;
                fault_addr_o = wide_q ? (base_q + ONE) : base_q;
                done_o       = !mem_err_i;
                commit_o     = !mem_err_i;
                if (pop_q) begin
                    rdata_o = wide_q ? {hi_q, mem_rdata_i} : {{BYTE_W{1'b0}}, mem_rdata_i};
                end
            end
            default: ;
        endcase
    end

    // R7: once accepted, the next cycle accesses memory at the captured base
    p_first_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (mem_en_o && mem_addr_o == base_q));
    // R8: a fault never coincides with a completion
    p_fault_excl_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !done_o);
endmodule

// File: rtl/stk_engine.sv
// Top: dual-convention byte stack engine.
module stk_engine
    import stk_pkg::*;
#(
    parameter int              SP_W     = 16,
    parameter int              BYTE_W   = 8,
    parameter logic [SP_W-1:0] SP_RESET = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_last_used,
    input  logic                op_valid,
    output logic                op_ready,
    input  logic                op_pop,
    input  logic                op_wide,
    input  logic [2*BYTE_W-1:0] op_wdata,
    output logic                op_done,
    output logic [2*BYTE_W-1:0] op_rdata,
    output logic                op_fault,
    output logic [SP_W-1:0]     fault_addr,
    input  logic                sp_load,
    input  logic [SP_W-1:0]     sp_load_val,
    output logic [SP_W-1:0]     sp_out,
    output logic                mem_en,
    output logic                mem_we,
    output logic [SP_W-1:0]     mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic [BYTE_W-1:0]   mem_rdata,
    input  logic                mem_err
);
    logic [SP_W-1:0] base, sp_after, commit_val;
    logic            busy, commit, load_eff;
    stk_conv_e       conv;

    assign conv     = stk_conv_e'(mode_last_used);
    assign load_eff = sp_load && !busy;

    stk_addr_calc #(.SP_W(SP_W)) i_calc (
        .sp_i       (sp_out),
        .conv_i     (conv),
        .pop_i      (op_pop),
        .wide_i     (op_wide),
        .base_o     (base),
        .sp_after_o (sp_after)
    );

    stk_fsm #(.SP_W(SP_W), .BYTE_W(BYTE_W)) i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid_i    (op_valid),
        .req_pop_i      (op_pop),
        .req_wide_i     (op_wide),
        .req_wdata_i    (op_wdata),
        .load_pending_i (sp_load),
        .base_i         (base),
        .sp_after_i     (sp_after),
        .req_ready_o    (op_ready),
        .busy_o         (busy),
        .mem_en_o       (mem_en),
        .mem_we_o       (mem_we),
        .mem_addr_o     (mem_addr),
        .mem_wdata_o    (mem_wdata),
        .mem_rdata_i    (mem_rdata),
        .mem_err_i      (mem_err),
        .done_o         (op_done),
        .rdata_o        (op_rdata),
        .fault_o        (op_fault),
        .fault_addr_o   (fault_addr),
        .commit_o       (commit),
        .commit_val_o   (commit_val)
    );

    stk_sp_reg #(.SP_W(SP_W), .SP_RESET(SP_RESET)) i_sp (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_i     (commit),
        .commit_val_i (commit_val),
        .load_i       (load_eff),
        .load_val_i   (sp_load_val),
        .sp_o         (sp_out)
    );

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);
    // R8: a fault leaves the pointer untouched
    p_fault_keeps_sp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_fault |=> $stable(sp_out));
    // R11: every completed request moves the pointer
    p_done_moves_sp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (sp_out != $past(sp_out)));
    // R9: an idle load lands on the next edge
    p_idle_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_load && op_ready == 1'b0 && !mem_en && !op_done && !op_fault && !busy)
        |=> (sp_out == $past(sp_load_val)));
    // R1: no memory traffic while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);
endmodule

// File: tb/test_stk_engine.sv
module test_stk_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_last_used = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic        op_pop = 1'b0;
    logic        op_wide = 1'b0;
    logic [15:0] op_wdata = '0;
    logic        op_done;
    logic [15:0] op_rdata;
    logic        op_fault;
    logic [15:0] fault_addr;
    logic        sp_load = 1'b0;
    logic [15:0] sp_load_val = '0;
    logic [15:0] sp_out;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_err;

    always #4 clk = ~clk; // 125 MHz

    stk_engine i_stk_engine (
        .clk(clk), .rst_n(rst_n), .mode_last_used(mode_last_used),
        .op_valid(op_valid), .op_ready(op_ready), .op_pop(op_pop),
        .op_wide(op_wide), .op_wdata(op_wdata), .op_done(op_done),
        .op_rdata(op_rdata), .op_fault(op_fault), .fault_addr(fault_addr),
        .sp_load(sp_load), .sp_load_val(sp_load_val), .sp_out(sp_out),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    // byte memory model, indexed by the low address byte
    logic [7:0]  mem [256];
    logic [7:0]  rd_q = '0;
    logic        err_q = 1'b0;
    logic        err_arm = 1'b0;
    logic [15:0] err_at = '0;
    int          acc_total = 0;
    int          acc_mark = 0;
    logic [15:0] first_addr = '0;
    assign mem_rdata = rd_q;
    assign mem_err   = err_q;

    always @(posedge clk) begin
        if (mem_en) begin
            if (acc_total == acc_mark) first_addr <= mem_addr;
            acc_total <= acc_total + 1;
            err_q <= err_arm && (mem_addr == err_at);
            if (mem_we && !(err_arm && mem_addr == err_at)) mem[mem_addr[7:0]] <= mem_wdata;
            rd_q <= mem[mem_addr[7:0]];
        end else begin
            err_q <= 1'b0;
        end
    end

    int tests = 0;
    int fails = 0;
    int cyc_cnt = 0;

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    task automatic fill();
        for (int i = 0; i < 256; i++) mem[i] = pat(16'(i));
    endtask

    task automatic load_sp(input logic [15:0] v);
        @(negedge clk);
        sp_load = 1'b1; sp_load_val = v;
        @(posedge clk);
        @(negedge clk);
        sp_load = 1'b0;
    endtask

    task automatic run_op(input logic pop, input logic wide, input logic [15:0] wd,
                          output logic [15:0] rd, output logic dn, output logic flt,
                          output logic [15:0] fa, output int cyc);
        @(negedge clk);
        acc_mark = acc_total;
        op_valid = 1'b1; op_pop = pop; op_wide = wide; op_wdata = wd;
        @(posedge clk);
        cyc = 0;
        do begin
            @(negedge clk);
            op_valid = 1'b0;
            cyc++;
        end while (!op_done && !op_fault && cyc < 8);
        rd = op_rdata; dn = op_done; flt = op_fault; fa = fault_addr;
        @(negedge clk);
    endtask

    initial begin
        while (cyc_cnt < 100000) begin
            @(posedge clk);
            cyc_cnt++;
        end
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] rd, fa, base, exp_sp, sz, exp_rd;
        logic        dn, flt;
        int          cyc, acc0;
        logic [15:0] sps [4];
        sps[0] = 16'h0080; sps[1] = 16'h0000; sps[2] = 16'hFFFF; sps[3] = 16'h0001;
        fill();
        repeat (3) @(negedge clk);
        chk(sp_out == 16'h0000, "R1 sp reset", sp_out, 16'h0000);
        chk(op_ready == 1'b1, "R1 ready", 16'(op_ready), 16'h1);
        chk(!mem_en && !op_done && !op_fault, "R1 quiet", {13'b0, mem_en, op_done, op_fault}, 16'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(sp_out == 16'h0000 && op_ready, "R1 after release", sp_out, 16'h0000);

        // R9: idle load, ready low while loading
        @(negedge clk);
        sp_load = 1'b1; sp_load_val = 16'h1234; op_valid = 1'b1;
        #1;
        chk(op_ready == 1'b0, "R9 ready low on load", 16'(op_ready), 16'h0);
        @(posedge clk);
        @(negedge clk);
        sp_load = 1'b0; op_valid = 1'b0;
        chk(sp_out == 16'h1234, "R9 idle load", sp_out, 16'h1234);
        chk(!mem_en, "R9 no accept during load", 16'(mem_en), 16'h0);

        // sweep: convention x width x direction x pointer
        for (int m = 0; m < 2; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int s = 0; s < 4; s++) begin
                    mode_last_used = m[0];
                    sz = (w != 0) ? 16'd2 : 16'd1;
                    // pop
                    fill();
                    load_sp(sps[s]);
                    base = (m != 0) ? sps[s] : sps[s] + 16'd1;
                    exp_rd = (w != 0) ? {pat(base), pat(base + 16'd1)} : {8'h00, pat(base)};
                    run_op(1'b1, w[0], 16'h0, rd, dn, flt, fa, cyc);
                    chk(dn && rd == exp_rd, (m != 0) ? "R6 pop data" : "R4 pop data", rd, exp_rd);
                    chk(cyc == ((w != 0) ? 3 : 2), "R7 pop latency", 16'(cyc), (w != 0) ? 16'd3 : 16'd2);
                    chk(first_addr == base, "R7 lower address first", first_addr, base);
                    exp_sp = sps[s] + sz;
                    chk(sp_out == exp_sp, (m != 0) ? "R6 pop sp" : "R4 pop sp R11", sp_out, exp_sp);
                    // push
                    load_sp(sps[s]);
                    base = (m != 0) ? sps[s] - sz : sps[s] - sz + 16'd1;
                    run_op(1'b0, w[0], 16'hC3A5 ^ 16'(s), rd, dn, flt, fa, cyc);
                    exp_sp = sps[s] - sz;
                    chk(dn && sp_out == exp_sp, (m != 0) ? "R5 push sp R11" : ((w != 0) ? "R3 push sp" : "R2 push sp"), sp_out, exp_sp);
                    if (w != 0) begin
                        chk(mem[base[7:0]] == 8'hC3 && mem[8'(base + 16'd1)] == (8'hA5 ^ 8'(s)),
                            (m != 0) ? "R5 push bytes" : "R3 push bytes",
                            {mem[base[7:0]], mem[8'(base + 16'd1)]}, {8'hC3, 8'hA5 ^ 8'(s)});
                    end else begin
                        chk(mem[base[7:0]] == (8'hA5 ^ 8'(s)), (m != 0) ? "R5 push byte" : "R2 push byte",
                            16'(mem[base[7:0]]), 16'(8'hA5 ^ 8'(s)));
                    end
                    chk(first_addr == base, "R7 push order", first_addr, base);
                end
            end
        end

        // R10: 8-bit pop zero-extended with high pattern byte
        fill(); mode_last_used = 1'b1;
        mem[8'h40] = 8'hFF;
        load_sp(16'h0040);
        run_op(1'b1, 1'b0, 16'h0, rd, dn, flt, fa, cyc);
        chk(rd == 16'h00FF, "R10 zero extend", rd, 16'h00FF);

        // R8: error on first byte of a 16-bit push (last-used)
        load_sp(16'h0050);
        err_arm = 1'b1; err_at = 16'h004E;
        acc0 = acc_total;
        run_op(1'b0, 1'b1, 16'hBEEF, rd, dn, flt, fa, cyc);
        chk(flt && !dn, "R8 fault no done", {14'b0, flt, dn}, 16'h2);
        chk(fa == 16'h004E, "R8 fault addr first", fa, 16'h004E);
        chk(acc_total - acc0 == 1, "R8 second byte skipped", 16'(acc_total - acc0), 16'd1);
        chk(sp_out == 16'h0050, "R8 sp kept", sp_out, 16'h0050);
        chk(op_ready == 1'b1, "R8 back to idle", 16'(op_ready), 16'h1);

        // R8: error on second byte of a 16-bit pop (next-free)
        mode_last_used = 1'b0; err_at = 16'h0052;
        run_op(1'b1, 1'b1, 16'h0, rd, dn, flt, fa, cyc);
        chk(flt && !dn && fa == 16'h0052, "R8 fault addr second", fa, 16'h0052);
        chk(sp_out == 16'h0050, "R8 sp kept pop", sp_out, 16'h0050);

        // R8: 8-bit push fault
        err_at = 16'h0050;
        run_op(1'b0, 1'b0, 16'h0011, rd, dn, flt, fa, cyc);
        chk(flt && fa == 16'h0050 && cyc == 2, "R8 narrow fault", fa, 16'h0050);
        chk(sp_out == 16'h0050, "R8 narrow sp kept", sp_out, 16'h0050);
        err_arm = 1'b0;

        // R9: load during a request is ignored
        @(negedge clk);
        op_valid = 1'b1; op_pop = 1'b0; op_wide = 1'b1; op_wdata = 16'h0102;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; sp_load = 1'b1; sp_load_val = 16'h7777;
        chk(op_ready == 1'b0, "R7 ready low busy", 16'(op_ready), 16'h0);
        @(negedge clk);
        @(negedge clk);
        sp_load = 1'b0;
        chk(op_done == 1'b1, "R7 wide done", 16'(op_done), 16'h1);
        @(negedge clk);
        chk(sp_out == 16'h004E, "R9 busy load ignored", sp_out, 16'h004E);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule